// File: doc/BRIEF.md
# Trace and Exception Sequencing Controller

This block decides which exception-processing requests follow the end of one instruction, and in what order. It watches the instruction boundary of the processor: the start of an instruction, where it latches the single-step trace flag, and the end of the instruction, which is either a normal completion or an abort with a cause. At that boundary it records up to three requests: an exception forced by the instruction itself (or a fault that aborted it), a trace exception, and a pending interrupt.

The recorded requests go out one at a time on a request/acknowledge pair. Each request is held with its kind and code until the exception processor acknowledges it. The next request appears in the cycle after the acknowledge. An interrupt that shows up while earlier requests are still waiting is added behind them. An abort caused by a processor reset empties everything at once.

The trace exception is placed after any exception caused by the instruction and before any interrupt. It is dropped whenever the instruction did not run to completion.

Top module: `trace_exc_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released, no request is presented (`exc_req_o` low) until an instruction boundary event occurs.
- R2: A completed instruction that began with the trace flag set produces a trace request (kind 1, code 0). One that began with the flag clear produces none.
- R3: The trace flag counts only as sampled on the `instr_start_i` strobe. Changes of `tbit_i` between start and completion have no effect.
- R4: A forced exception (kind 0, code = `force_code_i`) is presented before the trace request of the same instruction.
- R5: An interrupt pending at completion (kind 2, code 0) is presented after the forced and trace requests of that instruction.
- R6: An interrupt that rises while earlier requests still wait is queued behind them, giving the order forced, trace, interrupt.
- R7: An abort with cause bus error (1), address error (2), illegal (3) or privilege (4) presents a fault request (kind 3, code = cause) and no trace request. A pending interrupt follows it.
- R8: An abort with cause interrupt-preempted (5) presents only the interrupt request, with no trace and no fault.
- R9: An abort with cause reset (0) lowers `exc_req_o` in the same cycle, discards every queued request and clears the latched trace flag.
- R10: A presented request keeps its kind and code stable until acknowledged. An acknowledge while no request is presented has no effect. The next queued request appears in the cycle after the acknowledge.
- R11: Once every queued request is acknowledged, `exc_req_o` stays low until the next boundary event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_start_i | input | 1 | Strobe at the start of an instruction |
| tbit_i | input | 1 | Trace flag, sampled on `instr_start_i` |
| instr_done_i | input | 1 | Strobe: instruction completed |
| instr_abort_i | input | 1 | Strobe: instruction aborted |
| abort_cause_i | input | 3 | Abort cause: 0 reset, 1 bus, 2 address, 3 illegal, 4 privilege, 5 preempted |
| force_req_i | input | 1 | Instruction forces an exception, valid with `instr_done_i` |
| force_code_i | input | CODE_W | Code of the forced exception |
| irq_pend_i | input | 1 | Interrupt pending level |
| exc_ack_i | input | 1 | Exception processor took the presented request |
| exc_req_o | output | 1 | Request presented |
| exc_kind_o | output | 2 | 0 forced, 1 trace, 2 interrupt, 3 fault |
| exc_code_o | output | CODE_W | Forced code or abort cause, else 0 |

## Verification
The hardest situation to reach is an interrupt that arrives only after a traced trapping instruction has completed, while the trap request is still unacknowledged. To get there, the bench's acknowledging monitor holds off for several cycles, and the interrupt line is pulsed inside that window and dropped before the trap is taken. The reset-cause abort is another hard case. For it, the monitor is held off so that requests are still queued when the flush arrives, and the output is sampled in that same cycle.

// File: rtl/tes_pkg.sv
package tes_pkg;
  typedef enum logic [1:0] {
    EXC_FORCED = 2'd0,
    EXC_TRACE  = 2'd1,
    EXC_IRQ    = 2'd2,
    EXC_FAULT  = 2'd3
  } exc_kind_e;

  typedef enum logic [2:0] {
    AB_RESET   = 3'd0,
    AB_BUSERR  = 3'd1,
    AB_ADDRERR = 3'd2,
    AB_ILLEGAL = 3'd3,
    AB_PRIV    = 3'd4,
    AB_PREEMPT = 3'd5
  } abort_cause_e;

  // slot index is priority: lower index served first
  localparam int unsigned NUM_SLOTS  = 3;
  localparam int unsigned SLOT_INSTR = 0;
  localparam int unsigned SLOT_TRACE = 1;
  localparam int unsigned SLOT_IRQ   = 2;
endpackage

// File: rtl/tes_rst_sync.sv
module tes_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tes_trace_arm.sv
module tes_trace_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_start_i,
  input  logic tbit_i,
  input  logic end_i,
  input  logic flush_i,
  output logic armed_o
);
  logic armed_q;
  logic armed_d;
  logic armed_en;

  always_comb begin
    armed_en = flush_i | instr_start_i | end_i;
    if (flush_i)            armed_d = 1'b0;
    else if (instr_start_i) armed_d = tbit_i;
    else                    armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/tes_pending.sv
module tes_pending #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned SLOTS  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [SLOTS-1:0]  set_i,
  input  logic [SLOTS-1:0]  clr_i,
  input  logic              load_instr_i,
  input  logic [CODE_W-1:0] instr_code_i,
  input  logic              instr_fault_i,
  output logic [SLOTS-1:0]  pend_o,
  output logic [CODE_W-1:0] instr_code_o,
  output logic              instr_fault_o
);
  logic [SLOTS-1:0] pend_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic bit_d;
    logic bit_en;
    always_comb begin
      bit_en = flush_i | set_i[s] | clr_i[s];
      if (flush_i)       bit_d = 1'b0;
      else if (set_i[s]) bit_d = 1'b1;
      else               bit_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[s] <= 1'b0;
      else if (bit_en) pend_q[s] <= bit_d;
    end
  end

  logic [CODE_W-1:0] code_q;
  logic              fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      fault_q <= 1'b0;
    end else if (load_instr_i) begin
      code_q  <= instr_code_i;
      fault_q <= instr_fault_i;
    end
  end

  assign pend_o        = pend_q;
  assign instr_code_o  = code_q;
  assign instr_fault_o = fault_q;
endmodule

// File: rtl/tes_select.sv
module tes_select #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned SLOTS  = 3
) (
  input  logic [SLOTS-1:0]  pend_i,
  input  logic [CODE_W-1:0] instr_code_i,
  input  logic              instr_fault_i,
  output logic              req_o,
  output logic [SLOTS-1:0]  grant_o,
  output logic [1:0]        kind_o,
  output logic [CODE_W-1:0] code_o
);
  import tes_pkg::*;

  always_comb begin
    grant_o = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (pend_i[s]) grant_o = '0;
      if (pend_i[s]) grant_o[s] = 1'b1;
    end
    req_o = |pend_i;
  end

  always_comb begin
    kind_o = EXC_FORCED;
    code_o = '0;
    if (grant_o[SLOT_INSTR]) begin
      kind_o = instr_fault_i ? EXC_FAULT : EXC_FORCED;
      code_o = instr_code_i;
    end else if (grant_o[SLOT_TRACE]) begin
      kind_o = EXC_TRACE;
    end else if (grant_o[SLOT_IRQ]) begin
      kind_o = EXC_IRQ;
    end
  end
endmodule

// File: rtl/trace_exc_sequencer.sv
module trace_exc_sequencer #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_start_i,
  input  logic              tbit_i,
  input  logic              instr_done_i,
  input  logic              instr_abort_i,
  input  logic [2:0]        abort_cause_i,
  input  logic              force_req_i,
  input  logic [CODE_W-1:0] force_code_i,
  input  logic              irq_pend_i,
  input  logic              exc_ack_i,
  output logic              exc_req_o,
  output logic [1:0]        exc_kind_o,
  output logic [CODE_W-1:0] exc_code_o
);
  import tes_pkg::*;

  localparam int unsigned SLOTS = NUM_SLOTS;

  logic              rst_sync_n;
  logic              flush;
  logic              fault_abort;
  logic              boundary;
  logic              trace_arm;
  logic [SLOTS-1:0]  pend;
  logic [SLOTS-1:0]  set_vec;
  logic [SLOTS-1:0]  clr_vec;
  logic [SLOTS-1:0]  grant;
  logic              req_int;
  logic [CODE_W-1:0] instr_code_d;
  logic [CODE_W-1:0] instr_code_q;
  logic              instr_fault_q;
  logic              load_instr;

  tes_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    flush       = instr_abort_i & (abort_cause_i == AB_RESET);
    fault_abort = instr_abort_i & ((abort_cause_i == AB_BUSERR)  |
                                   (abort_cause_i == AB_ADDRERR) |
                                   (abort_cause_i == AB_ILLEGAL) |
                                   (abort_cause_i == AB_PRIV));
    boundary    = instr_done_i | (instr_abort_i & ~flush);
  end

  tes_trace_arm i_arm (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .instr_start_i (instr_start_i),
    .tbit_i        (tbit_i),
    .end_i         (instr_done_i | instr_abort_i),
    .flush_i       (flush),
    .armed_o       (trace_arm)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[SLOT_INSTR] = (instr_done_i & force_req_i) | fault_abort;
    set_vec[SLOT_TRACE] = instr_done_i & trace_arm;
    set_vec[SLOT_IRQ]   = irq_pend_i &
                          (boundary | pend[SLOT_INSTR] | pend[SLOT_TRACE]);
    clr_vec    = grant & {SLOTS{exc_ack_i & req_int}};
    load_instr = set_vec[SLOT_INSTR];
    if (fault_abort) instr_code_d = CODE_W'(abort_cause_i);
    else             instr_code_d = force_code_i;
  end

  tes_pending #(.CODE_W(CODE_W), .SLOTS(SLOTS)) i_pend (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .flush_i       (flush),
    .set_i         (set_vec),
    .clr_i         (clr_vec),
    .load_instr_i  (load_instr),
    .instr_code_i  (instr_code_d),
    .instr_fault_i (fault_abort),
    .pend_o        (pend),
    .instr_code_o  (instr_code_q),
    .instr_fault_o (instr_fault_q)
  );

  tes_select #(.CODE_W(CODE_W), .SLOTS(SLOTS)) i_sel (
    .pend_i        (pend),
    .instr_code_i  (instr_code_q),
    .instr_fault_i (instr_fault_q),
    .req_o         (req_int),
    .grant_o       (grant),
    .kind_o        (exc_kind_o),
    .code_o        (exc_code_o)
  );

  assign exc_req_o = req_int & ~flush;
endmodule

// File: rtl/tes_checker.sv
module tes_checker #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_done_i,
  input logic              instr_abort_i,
  input logic [2:0]        abort_cause_i,
  input logic              force_req_i,
  input logic              irq_pend_i,
  input logic              exc_ack_i,
  input logic              exc_req_o,
  input logic [1:0]        exc_kind_o,
  input logic [CODE_W-1:0] exc_code_o,
  input logic              trace_arm
);
  logic flush_c;
  assign flush_c = instr_abort_i & (abort_cause_i == 3'd0);

  // R10: held request keeps kind and code until acknowledged
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req_o && !exc_ack_i && !instr_done_i && !instr_abort_i)
      |=> (flush_c || (exc_req_o && $stable(exc_kind_o) && $stable(exc_code_o))));

  // R9: reset-cause abort leaves nothing presented afterwards
  assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_c |=> !exc_req_o);

  // R7: an abort on an idle controller never yields a trace request
  assert_no_trace_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_abort_i && !exc_req_o) |=> !(exc_req_o && exc_kind_o == 2'd1));

  // R11: idle stays idle without a boundary event
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req_o && !instr_done_i && !instr_abort_i) |=> !exc_req_o);

  // R2: completion with trace disarmed and nothing else produces nothing
  assert_no_trace_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done_i && !trace_arm && !force_req_i && !irq_pend_i && !exc_req_o)
      |=> !exc_req_o);
endmodule

bind trace_exc_sequencer tes_checker #(.CODE_W(CODE_W)) i_tes_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_done_i  (instr_done_i),
  .instr_abort_i (instr_abort_i),
  .abort_cause_i (abort_cause_i),
  .force_req_i   (force_req_i),
  .irq_pend_i    (irq_pend_i),
  .exc_ack_i     (exc_ack_i),
  .exc_req_o     (exc_req_o),
  .exc_kind_o    (exc_kind_o),
  .exc_code_o    (exc_code_o),
  .trace_arm     (trace_arm)
);

// File: tb/test_trace_exc_sequencer.sv
`timescale 1ns/1ps
module test_trace_exc_sequencer;
  localparam int CODE_W = 4;

  logic              clk;
  logic              rst_n;
  logic              instr_start_i, tbit_i, instr_done_i, instr_abort_i;
  logic [2:0]        abort_cause_i;
  logic              force_req_i;
  logic [CODE_W-1:0] force_code_i;
  logic              irq_pend_i;
  logic              exc_ack_i;
  logic              exc_req_o;
  logic [1:0]        exc_kind_o;
  logic [CODE_W-1:0] exc_code_o;

  logic mon_ack, stray_ack, hold_ack;
  int   ack_dly;
  int   errors, checks;
  string cur_req;
  logic [1:0]        exp_kind_q[$];
  logic [CODE_W-1:0] exp_code_q[$];

  assign exc_ack_i = mon_ack | stray_ack;

  trace_exc_sequencer #(.CODE_W(CODE_W)) i_trace_exc_sequencer (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [CODE_W-1:0] c);
    exp_kind_q.push_back(k);
    exp_code_q.push_back(c);
  endtask

  // scoreboard monitor: compares and acknowledges
  initial begin
    mon_ack = 1'b0;
    forever begin
      @(negedge clk);
      mon_ack = 1'b0;
      if (exc_req_o && !hold_ack) begin
        logic [1:0]        k0;
        logic [CODE_W-1:0] c0;
        k0 = exc_kind_o;
        c0 = exc_code_o;
        for (int i = 0; i < ack_dly; i++) begin
          @(negedge clk);
          check({cur_req, " R10 hold"}, {exc_req_o, exc_kind_o, exc_code_o}, {1'b1, k0, c0});
        end
        if (exp_kind_q.size() == 0) begin
          check({cur_req, " unexpected request"}, 1, 0);
        end else begin
          check({cur_req, " kind"}, exc_kind_o, exp_kind_q.pop_front());
          check({cur_req, " code"}, exc_code_o, exp_code_q.pop_front());
        end
        mon_ack = 1'b1;
      end
    end
  end

  task automatic run_instr(input logic tb_start, input logic tb_mid, input logic frc,
                           input logic [CODE_W-1:0] code, input logic irq);
    @(negedge clk); instr_start_i = 1; tbit_i = tb_start;
    @(negedge clk); instr_start_i = 0; tbit_i = tb_mid;
    @(negedge clk); instr_done_i = 1; force_req_i = frc; force_code_i = code; irq_pend_i = irq;
    @(negedge clk); instr_done_i = 0; force_req_i = 0; irq_pend_i = 0;
  endtask

  task automatic run_abort(input logic tb_start, input logic [2:0] cause, input logic irq);
    @(negedge clk); instr_start_i = 1; tbit_i = tb_start;
    @(negedge clk); instr_start_i = 0;
    @(negedge clk); instr_abort_i = 1; abort_cause_i = cause; irq_pend_i = irq;
    @(negedge clk); instr_abort_i = 0; irq_pend_i = 0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 40 && (exp_kind_q.size() != 0 || exc_req_o); i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check({req, " R11 drained"}, {exp_kind_q.size() == 0, exc_req_o}, 2'b10);
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    errors = 0; checks = 0; cur_req = "R1";
    rst_n = 0; hold_ack = 1; ack_dly = 0; stray_ack = 0;
    instr_start_i = 0; tbit_i = 0; instr_done_i = 0; instr_abort_i = 0;
    abort_cause_i = 0; force_req_i = 0; force_code_i = 0; irq_pend_i = 0;
    repeat (3) @(negedge clk);
    check("R1 req in reset", exc_req_o, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R1 req after reset", exc_req_o, 0);
    hold_ack = 0;

    cur_req = "R2";   push(2'd1, 0); run_instr(1, 1, 0, 0, 0); drain("R2 traced");
    cur_req = "R2";   run_instr(0, 0, 0, 0, 0); drain("R2 untraced");
    cur_req = "R3";   push(2'd1, 0); run_instr(1, 0, 0, 0, 0); drain("R3 flag drops");
    cur_req = "R3";   run_instr(0, 1, 0, 0, 0); drain("R3 flag rises");
    cur_req = "R4";   push(2'd0, 4'hA); push(2'd1, 0); run_instr(1, 1, 1, 4'hA, 0); drain("R4");
    cur_req = "R5";   push(2'd1, 0); push(2'd2, 0); run_instr(1, 1, 0, 0, 1); drain("R5");
    cur_req = "R5";   push(2'd0, 4'h3); push(2'd2, 0); run_instr(0, 0, 1, 4'h3, 1); drain("R5 no trace");

    cur_req = "R6"; ack_dly = 4;
    push(2'd0, 4'h7); push(2'd1, 0); push(2'd2, 0);
    run_instr(1, 1, 1, 4'h7, 0);
    irq_pend_i = 1; repeat (2) @(negedge clk); irq_pend_i = 0;
    drain("R6"); ack_dly = 0;

    for (int c = 1; c <= 4; c++) begin
      cur_req = "R7"; push(2'd3, CODE_W'(c));
      run_abort(1, 3'(c), 0); drain("R7 fault");
    end
    cur_req = "R7"; push(2'd3, 4'h2); push(2'd2, 0); run_abort(1, 3'd2, 1); drain("R7 fault irq");
    cur_req = "R8"; push(2'd2, 0); run_abort(1, 3'd5, 1); drain("R8 preempt");

    // R10: stray acknowledge while idle must not disturb the next sequence
    cur_req = "R10";
    @(negedge clk); stray_ack = 1; @(negedge clk); stray_ack = 0;
    check("R10 stray ack idle", exc_req_o, 0);
    push(2'd0, 4'h5); push(2'd1, 0); run_instr(1, 1, 1, 4'h5, 0); drain("R10");

    // R9: flush with queued requests
    cur_req = "R9"; hold_ack = 1;
    run_instr(1, 1, 1, 4'h9, 1);
    check("R9 queued before flush", exc_req_o, 1);
    instr_abort_i = 1; abort_cause_i = 3'd0;
    #1 check("R9 same-cycle drop", exc_req_o, 0);
    @(negedge clk); instr_abort_i = 0;
    check("R9 after flush", exc_req_o, 0);
    repeat (3) @(negedge clk);
    check("R9 stays empty", exc_req_o, 0);
    // armed flag cleared by flush
    @(negedge clk); instr_start_i = 1; tbit_i = 1;
    @(negedge clk); instr_start_i = 0;
    @(negedge clk); instr_abort_i = 1; abort_cause_i = 3'd0;
    @(negedge clk); instr_abort_i = 0;
    @(negedge clk); instr_done_i = 1;
    @(negedge clk); instr_done_i = 0;
    check("R9 trace flag cleared", exc_req_o, 0);
    hold_ack = 0;
    drain("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule